// File: doc/BRIEF.md
# Two-Level IO Translation Table Walker

This block turns a 32-bit device address into a physical address. It reads a two-level translation table that software has placed in memory. A requester presents the address together with the current table root. The walker then fetches a first-level descriptor over a single-outstanding word read port. A first-level entry may map the address directly, either as a 1 MB section or as a 16 MB supersection. It may instead point to a 1 KB second-level table. In that case one more word is fetched, and that word maps a 4 KB small page or a 64 KB large page.

Supersections and large pages need no special search. Software repeats their descriptor across 16 neighbouring slots, so whichever slot the address indexes already carries the full mapping. An empty or malformed descriptor at either level ends the walk with a fault flag and the requesting address. The result stays on the outputs until the requester acknowledges it. Only one walk runs at a time. The walker never writes to memory.

Top module: `iopt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `res_valid` and `mem_rd_valid` are 0.
- R2: The first read of every walk goes to `{tbl_base[31:14], va[31:20], 2'b00}`. Bits 13:0 of the table root have no effect on any read address or result.
- R3: A first-level descriptor with bits 1:0 = `10` and bit 18 = 0 is a 1 MB section. The result is `pa = {desc[31:20], va[19:0]}` with size code 2, and the walk issues no second read.
- R4: A first-level descriptor with bits 1:0 = `10` and bit 18 = 1 is a 16 MB supersection. The result is `pa = {desc[31:24], va[23:0]}` with size code 3, and there is no second read.
- R5: A first-level descriptor with bits 1:0 = `01` starts a second read at `{desc[31:10], va[19:12], 2'b00}`. Descriptor bits 9:0 have no effect on that address.
- R6: A second-level descriptor with bits 1:0 = `10` is a 4 KB page. The result is `pa = {desc[31:12], va[11:0]}` with size code 0.
- R7: A second-level descriptor with bits 1:0 = `01` is a 64 KB page. The result is `pa = {desc[31:16], va[15:0]}` with size code 1.
- R8: Encoding `00` (including an all-zero descriptor) or `11` at either level ends the walk with `res_fault` = 1, `res_fault_addr` equal to the requesting address, and `res_pa` = 0 and size 0. No further read follows. On a successful walk `res_fault` and `res_fault_addr` are 0.
- R9: `req_ready` is 1 only while idle. A `req_valid` raised during a walk is not accepted and does not alter the walk in progress.
- R10: The result fields stay stable while `res_valid` is 1 and `res_ack` is 0. The cycle after an acknowledge, `res_valid` is 0 and `req_ready` is 1.
- R11: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, the read request stays raised with an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_addr | input | 32 | Device address to translate |
| tbl_base | input | 32 | Root of the first-level table (16 KB aligned) |
| mem_rd_valid | output | 1 | Word read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Translation result present |
| res_ack | input | 1 | Requester takes the result |
| res_pa | output | 32 | Translated physical address |
| res_size | output | 2 | Page size: 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB |
| res_fault | output | 1 | Walk ended on an invalid descriptor |
| res_fault_addr | output | 32 | Requesting address when faulted, else 0 |

## Verification
Some properties are checked on every cycle. These are the handshake rules (read request held under back-pressure, result held until acknowledged, no acceptance while busy), the first-read address formed from the captured root and address, the limit of two reads per walk, the page-offset bits of every successful result, and the fault report carrying the requesting address. Other behaviour shows only in the bench's scenarios against a table image. This covers the choice between section and supersection by bit 18, the replicated supersection and large-page slots, the second-level address with the low descriptor bits ignored, the root's low bits being ignored, the fault cases at each level, and whether the physical base bits are right for each size.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

   // Page size code reported with each result
   typedef enum logic [1:0] {
      PG_4K  = 2'd0,
      PG_64K = 2'd1,
      PG_1M  = 2'd2,
      PG_16M = 2'd3
   } pg_size_e;

   // Classification of a fetched descriptor
   typedef enum logic [1:0] {
      DK_FAULT = 2'd0,
      DK_TABLE = 2'd1,
      DK_LEAF  = 2'd2
   } desc_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_L1_REQ  = 3'd1,
      ST_L1_WAIT = 3'd2,
      ST_L2_REQ  = 3'd3,
      ST_L2_WAIT = 3'd4,
      ST_DONE    = 3'd5
   } walk_st_e;

   // Low two bits of a descriptor
   localparam logic [1:0] ENC_L1_TABLE = 2'b01;
   localparam logic [1:0] ENC_L1_BLOCK = 2'b10;
   localparam logic [1:0] ENC_L2_SMALL = 2'b10;
   localparam logic [1:0] ENC_L2_LARGE = 2'b01;

endpackage

// File: rtl/iopt_addr_gen.sv
module iopt_addr_gen #(
   parameter int ADDR_W = 32,
   parameter int L1_LSB = 20,
   parameter int L2_LSB = 12
) (
   input  logic              lvl2,
   input  logic [ADDR_W-1:0] root,
   input  logic [ADDR_W-1:0] va,
   input  logic [ADDR_W-1:0] l1_desc,
   output logic [ADDR_W-1:0] rd_addr
);
   localparam int BYTE_LOG2 = $clog2(ADDR_W / 8);
   localparam int L1_IDX_W  = ADDR_W - L1_LSB;
   localparam int L2_IDX_W  = L1_LSB - L2_LSB;
   localparam int L1_ALIGN  = L1_IDX_W + BYTE_LOG2;
   localparam int L2_ALIGN  = L2_IDX_W + BYTE_LOG2;

   logic [ADDR_W-1:0] l1_addr;
   logic [ADDR_W-1:0] l2_addr;

   // First level: root aligned to the table size, indexed by the top bits
   assign l1_addr = {root[ADDR_W-1:L1_ALIGN], va[ADDR_W-1:L1_LSB], {BYTE_LOG2{1'b0}}};
   // Second level: table pointer with its low bits dropped, indexed by the middle bits
   assign l2_addr = {l1_desc[ADDR_W-1:L2_ALIGN], va[L1_LSB-1:L2_LSB], {BYTE_LOG2{1'b0}}};

   assign rd_addr = lvl2 ? l2_addr : l1_addr;

endmodule

// File: rtl/iopt_desc_decode.sv
module iopt_desc_decode
   import iopt_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int L1_LSB    = 20,
   parameter int L2_LSB    = 12,
   parameter int REPL_LOG2 = 4,
   parameter int SUPER_BIT = 18
) (
   input  logic              lvl2,
   input  logic [ADDR_W-1:0] desc,
   input  logic [ADDR_W-1:0] va,
   output desc_kind_e        kind,
   output logic [ADDR_W-1:0] pa,
   output pg_size_e          size
);
   localparam int SUPER_LSB = L1_LSB + REPL_LOG2;
   localparam int LARGE_LSB = L2_LSB + REPL_LOG2;

   localparam logic [ADDR_W-1:0] OFS_SECT  = {ADDR_W{1'b1}} >> (ADDR_W - L1_LSB);
   localparam logic [ADDR_W-1:0] OFS_SUPER = {ADDR_W{1'b1}} >> (ADDR_W - SUPER_LSB);
   localparam logic [ADDR_W-1:0] OFS_SMALL = {ADDR_W{1'b1}} >> (ADDR_W - L2_LSB);
   localparam logic [ADDR_W-1:0] OFS_LARGE = {ADDR_W{1'b1}} >> (ADDR_W - LARGE_LSB);

   desc_kind_e        cand_kind [2];
   logic [ADDR_W-1:0] cand_pa   [2];
   pg_size_e          cand_size [2];

   for (genvar lv = 0; lv < 2; lv++) begin : g_lvl
      if (lv == 0) begin : g_first
         always_comb begin
            cand_kind[lv] = DK_FAULT;
            cand_pa[lv]   = '0;
            cand_size[lv] = PG_4K;
            unique case (desc[1:0])
               ENC_L1_TABLE: cand_kind[lv] = DK_TABLE;
               ENC_L1_BLOCK: begin
                  cand_kind[lv] = DK_LEAF;
                  if (desc[SUPER_BIT]) begin
                     cand_pa[lv]   = (desc & ~OFS_SUPER) | (va & OFS_SUPER);
                     cand_size[lv] = PG_16M;
                  end else begin
                     cand_pa[lv]   = (desc & ~OFS_SECT) | (va & OFS_SECT);
                     cand_size[lv] = PG_1M;
                  end
               end
               default: cand_kind[lv] = DK_FAULT;
            endcase
         end
      end else begin : g_second
         always_comb begin
            cand_kind[lv] = DK_FAULT;
            cand_pa[lv]   = '0;
            cand_size[lv] = PG_4K;
            unique case (desc[1:0])
               ENC_L2_SMALL: begin
                  cand_kind[lv] = DK_LEAF;
                  cand_pa[lv]   = (desc & ~OFS_SMALL) | (va & OFS_SMALL);
                  cand_size[lv] = PG_4K;
               end
               ENC_L2_LARGE: begin
                  cand_kind[lv] = DK_LEAF;
                  cand_pa[lv]   = (desc & ~OFS_LARGE) | (va & OFS_LARGE);
                  cand_size[lv] = PG_64K;
               end
               default: cand_kind[lv] = DK_FAULT;
            endcase
         end
      end
   end

   assign kind = cand_kind[lvl2];
   assign pa   = cand_pa[lvl2];
   assign size = cand_size[lvl2];

endmodule

// File: rtl/iopt_ctrl.sv
module iopt_ctrl
   import iopt_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic              mem_rd_ready,
   input  logic              mem_rsp_valid,
   input  logic [ADDR_W-1:0] mem_rsp_data,
   input  logic              res_ack,
   input  desc_kind_e        dec_kind,
   input  logic [ADDR_W-1:0] dec_pa,
   input  pg_size_e          dec_size,
   output logic              req_ready,
   output logic              rd_req,
   output logic              lvl2,
   output logic [ADDR_W-1:0] va_q,
   output logic [ADDR_W-1:0] root_q,
   output logic [ADDR_W-1:0] l1_desc_q,
   output logic              done,
   output logic [ADDR_W-1:0] pa_q,
   output pg_size_e          size_q,
   output logic              fault_q,
   output logic [ADDR_W-1:0] fault_addr_q
);
   walk_st_e st_q, st_d;
   logic     rsp_take;

   assign rsp_take = mem_rsp_valid && (st_q == ST_L1_WAIT || st_q == ST_L2_WAIT);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:    if (req_valid) st_d = ST_L1_REQ;
         ST_L1_REQ:  if (mem_rd_ready) st_d = ST_L1_WAIT;
         ST_L2_REQ:  if (mem_rd_ready) st_d = ST_L2_WAIT;
         ST_L1_WAIT: if (mem_rsp_valid) st_d = (dec_kind == DK_TABLE) ? ST_L2_REQ : ST_DONE;
         ST_L2_WAIT: if (mem_rsp_valid) st_d = ST_DONE;
         ST_DONE:    if (res_ack) st_d = ST_IDLE;
         default:    st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         va_q         <= '0;
         root_q       <= '0;
         l1_desc_q    <= '0;
         pa_q         <= '0;
         size_q       <= PG_4K;
         fault_q      <= 1'b0;
         fault_addr_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && req_valid) begin
            va_q   <= req_addr;
            root_q <= tbl_base;
         end
         if (rsp_take) begin
            unique case (dec_kind)
               DK_TABLE: l1_desc_q <= mem_rsp_data;
               DK_LEAF: begin
                  pa_q         <= dec_pa;
                  size_q       <= dec_size;
                  fault_q      <= 1'b0;
                  fault_addr_q <= '0;
               end
               default: begin
                  pa_q         <= '0;
                  size_q       <= PG_4K;
                  fault_q      <= 1'b1;
                  fault_addr_q <= va_q;
               end
            endcase
         end
      end
   end

   assign req_ready = (st_q == ST_IDLE);
   assign rd_req    = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
   assign lvl2      = (st_q == ST_L2_REQ) || (st_q == ST_L2_WAIT);
   assign done      = (st_q == ST_DONE);

endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
   import iopt_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int L1_LSB    = 20,
   parameter int L2_LSB    = 12,
   parameter int REPL_LOG2 = 4,
   parameter int SUPER_BIT = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ADDR_W-1:0] tbl_base,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [ADDR_W-1:0] mem_rsp_data,
   output logic              res_valid,
   input  logic              res_ack,
   output logic [ADDR_W-1:0] res_pa,
   output logic [1:0]        res_size,
   output logic              res_fault,
   output logic [ADDR_W-1:0] res_fault_addr
);
   // Elaboration-time parameter checks
   if (ADDR_W % 8 != 0 || ADDR_W < 16) begin : g_bad_addr_w
      $error("ADDR_W must be a whole number of bytes, 16 or more");
   end
   if (L2_LSB + REPL_LOG2 >= L1_LSB) begin : g_bad_l2_split
      $error("second-level span must exceed the replicated large page");
   end
   if (L1_LSB + REPL_LOG2 > ADDR_W) begin : g_bad_super
      $error("supersection span exceeds the address width");
   end
   if (SUPER_BIT < 2 || SUPER_BIT >= L1_LSB) begin : g_bad_flag
      $error("SUPER_BIT must sit between the type field and the section base");
   end

   logic              lvl2;
   logic [ADDR_W-1:0] va_q;
   logic [ADDR_W-1:0] root_q;
   logic [ADDR_W-1:0] l1_desc_q;
   logic [ADDR_W-1:0] pa_q;
   logic [ADDR_W-1:0] fault_addr_q;
   logic [ADDR_W-1:0] dec_pa;
   logic              fault_q;
   logic              done;
   desc_kind_e        dec_kind;
   pg_size_e          dec_size;
   pg_size_e          size_q;

   iopt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_addr     (req_addr),
      .tbl_base     (tbl_base),
      .mem_rd_ready (mem_rd_ready),
      .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data),
      .res_ack      (res_ack),
      .dec_kind     (dec_kind),
      .dec_pa       (dec_pa),
      .dec_size     (dec_size),
      .req_ready    (req_ready),
      .rd_req       (mem_rd_valid),
      .lvl2         (lvl2),
      .va_q         (va_q),
      .root_q       (root_q),
      .l1_desc_q    (l1_desc_q),
      .done         (done),
      .pa_q         (pa_q),
      .size_q       (size_q),
      .fault_q      (fault_q),
      .fault_addr_q (fault_addr_q)
   );

   iopt_addr_gen #(
      .ADDR_W(ADDR_W), .L1_LSB(L1_LSB), .L2_LSB(L2_LSB)
   ) u_agen (
      .lvl2   (lvl2),
      .root   (root_q),
      .va     (va_q),
      .l1_desc(l1_desc_q),
      .rd_addr(mem_rd_addr)
   );

   iopt_desc_decode #(
      .ADDR_W(ADDR_W), .L1_LSB(L1_LSB), .L2_LSB(L2_LSB),
      .REPL_LOG2(REPL_LOG2), .SUPER_BIT(SUPER_BIT)
   ) u_dec (
      .lvl2(lvl2),
      .desc(mem_rsp_data),
      .va  (va_q),
      .kind(dec_kind),
      .pa  (dec_pa),
      .size(dec_size)
   );

   assign res_valid      = done;
   assign res_pa         = pa_q;
   assign res_size       = size_q;
   assign res_fault      = fault_q;
   assign res_fault_addr = fault_addr_q;

endmodule

// File: rtl/iopt_walker_chk.sv
module iopt_walker_chk #(
   parameter int ADDR_W = 32,
   parameter int L1_LSB = 20,
   parameter int L2_LSB = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [ADDR_W-1:0] tbl_base,
   input logic              mem_rd_valid,
   input logic              mem_rd_ready,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              res_valid,
   input logic              res_ack,
   input logic [ADDR_W-1:0] res_pa,
   input logic [1:0]        res_size,
   input logic              res_fault,
   input logic [ADDR_W-1:0] res_fault_addr
);
   localparam int BYTE_LOG2 = $clog2(ADDR_W / 8);
   localparam int L1_ALIGN  = ADDR_W - L1_LSB + BYTE_LOG2;

   logic [ADDR_W-1:0] c_va;
   logic [ADDR_W-1:0] c_root;
   logic [1:0]        c_reads;
   logic [ADDR_W-1:0] ofs_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_va    <= '0;
         c_root  <= '0;
         c_reads <= '0;
      end else if (req_valid && req_ready) begin
         c_va    <= req_addr;
         c_root  <= tbl_base;
         c_reads <= '0;
      end else if (mem_rd_valid && mem_rd_ready && c_reads != 2'd3) begin
         c_reads <= c_reads + 2'd1;
      end
   end

   always_comb begin
      unique case (res_size)
         2'd0:    ofs_mask = {ADDR_W{1'b1}} >> (ADDR_W - L2_LSB);
         2'd1:    ofs_mask = {ADDR_W{1'b1}} >> (ADDR_W - L2_LSB - 4);
         2'd2:    ofs_mask = {ADDR_W{1'b1}} >> (ADDR_W - L1_LSB);
         default: ofs_mask = {ADDR_W{1'b1}} >> (ADDR_W - L1_LSB - 4);
      endcase
   end

   a_r2_first_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid && c_reads == 2'd0 |->
         mem_rd_addr == {c_root[ADDR_W-1:L1_ALIGN], c_va[ADDR_W-1:L1_LSB], {BYTE_LOG2{1'b0}}});

   // R3, R4, R6, R7: the untranslated offset bits pass through
   a_r3_leaf_offset: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_fault |-> (res_pa & ofs_mask) == (c_va & ofs_mask));

   a_r5_two_reads_max: assert property (@(posedge clk) disable iff (!rst_n)
      c_reads <= 2'd2);

   a_r8_fault_report: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_fault |-> res_fault_addr == c_va && res_pa == '0);

   a_r8_clean_success: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_fault |-> res_fault_addr == '0);

   a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid || res_valid |-> !req_ready);

   a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_ack |=> res_valid && $stable(res_pa) && $stable(res_size)
         && $stable(res_fault) && $stable(res_fault_addr));

   a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_ack |=> !res_valid && req_ready);

   a_r11_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

endmodule

bind iopt_walker iopt_walker_chk #(
   .ADDR_W(ADDR_W), .L1_LSB(L1_LSB), .L2_LSB(L2_LSB)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_addr      (req_addr),
   .tbl_base      (tbl_base),
   .mem_rd_valid  (mem_rd_valid),
   .mem_rd_ready  (mem_rd_ready),
   .mem_rd_addr   (mem_rd_addr),
   .res_valid     (res_valid),
   .res_ack       (res_ack),
   .res_pa        (res_pa),
   .res_size      (res_size),
   .res_fault     (res_fault),
   .res_fault_addr(res_fault_addr)
);

// File: tb/iopt_walker_bench.sv
module iopt_walker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [31:0] tbl_base = '0;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b0;
   logic [31:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        res_valid;
   logic        res_ack = 1'b0;
   logic [31:0] res_pa;
   logic [1:0]  res_size;
   logic        res_fault;
   logic [31:0] res_fault_addr;

   always #5 clk = ~clk;

   iopt_walker u_iopt_walker (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .tbl_base(tbl_base),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .res_valid(res_valid), .res_ack(res_ack), .res_pa(res_pa), .res_size(res_size),
      .res_fault(res_fault), .res_fault_addr(res_fault_addr)
   );

   typedef struct {
      logic [31:0] pa;
      logic [1:0]  sz;
      logic        flt;
      logic [31:0] fa;
      string       tag;
   } exp_res_t;

   typedef struct {
      logic [31:0] addr;
      string       tag;
   } exp_rd_t;

   exp_res_t    res_q[$];
   exp_rd_t     rd_q[$];
   logic [31:0] mem [logic [31:0]];
   int          n_checks = 0;
   int          n_fails  = 0;
   int          hs_cnt   = 0;

   localparam logic [31:0] ROOT_A = 32'h0008_0000;
   localparam logic [31:0] ROOT_B = 32'h0010_4000;
   localparam logic [31:0] L2_TBL = 32'h0010_0400;

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
      end
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
   endtask

   // Expected reads and result computed from the requirements
   task automatic expect_walk(input logic [31:0] va, input logic [31:0] root, input string tag);
      exp_res_t    e;
      logic [31:0] a1, a2, d1, d2;
      e.tag = tag; e.pa = '0; e.sz = 2'd0; e.flt = 1'b1; e.fa = va;
      a1 = {root[31:14], va[31:20], 2'b00};
      rd_q.push_back('{a1, {tag, " R2 first read"}});
      d1 = rd(a1);
      if (d1[1:0] == 2'b10) begin
         e.flt = 1'b0; e.fa = '0;
         if (d1[18]) begin e.pa = {d1[31:24], va[23:0]}; e.sz = 2'd3; end
         else        begin e.pa = {d1[31:20], va[19:0]}; e.sz = 2'd2; end
      end else if (d1[1:0] == 2'b01) begin
         a2 = {d1[31:10], va[19:12], 2'b00};
         rd_q.push_back('{a2, {tag, " R5 second read"}});
         d2 = rd(a2);
         if (d2[1:0] == 2'b10) begin
            e.flt = 1'b0; e.fa = '0; e.pa = {d2[31:12], va[11:0]}; e.sz = 2'd0;
         end else if (d2[1:0] == 2'b01) begin
            e.flt = 1'b0; e.fa = '0; e.pa = {d2[31:16], va[15:0]}; e.sz = 2'd1;
         end
      end
      res_q.push_back(e);
   endtask

   task automatic drive(input logic [31:0] va, input logic [31:0] root, input string tag,
                        input bit poke_busy);
      do @(negedge clk); while (!req_ready);
      expect_walk(va, root, tag);
      req_valid = 1'b1; req_addr = va; tbl_base = root;
      @(negedge clk);
      if (poke_busy) begin
         req_addr = 32'h0012_3456; tbl_base = ROOT_B;
         for (int k = 0; k < 2; k++) begin
            chk(!req_ready, "R9", "req_ready during walk", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
         end
      end
      req_valid = 1'b0;
   endtask

   // Read handshakes seen at the clock edge
   always @(posedge clk) if (rst_n && mem_rd_valid && mem_rd_ready) hs_cnt <= hs_cnt + 1;

   // Memory responder: stalls on some cycles, answers after 1 to 3 cycles
   initial begin
      int          seen = 0;
      int          cyc = 0;
      int          lat = 0;
      bit          pend = 0;
      bit          stall_prev = 0;
      logic [31:0] stall_addr = '0;
      logic [31:0] pend_addr = '0;
      exp_rd_t     er;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (stall_prev)
            chk(mem_rd_valid && mem_rd_addr == stall_addr, "R11", "held read addr",
                mem_rd_addr, stall_addr);
         if (hs_cnt != seen) begin
            seen = hs_cnt;
            pend_addr = mem_rd_addr;
            if (rd_q.size() == 0) chk(1'b0, "R5", "unexpected read", pend_addr, 32'h0);
            else begin
               er = rd_q.pop_front();
               chk(pend_addr == er.addr, er.tag, "read addr", pend_addr, er.addr);
            end
            pend = 1; lat = 1 + (cyc % 3);
         end
         if (pend) begin
            if (lat <= 1) begin
               mem_rsp_valid = 1'b1; mem_rsp_data = rd(pend_addr); pend = 0;
            end else lat--;
         end
         mem_rd_ready = !pend && ((cyc % 4) != 1);
         stall_prev = mem_rd_valid && !mem_rd_ready;
         stall_addr = mem_rd_addr;
         cyc++;
      end
   end

   // Result monitor and scoreboard
   initial begin
      exp_res_t    e;
      logic [31:0] c_pa, c_fa;
      logic [1:0]  c_sz;
      logic        c_f;
      forever begin
         @(negedge clk);
         if (rst_n && res_valid) begin
            c_pa = res_pa; c_sz = res_size; c_f = res_fault; c_fa = res_fault_addr;
            if (res_q.size() == 0) chk(1'b0, "R9", "unexpected result", c_pa, 32'h0);
            else begin
               e = res_q.pop_front();
               chk(c_f == e.flt, e.tag, "fault flag", {31'd0, c_f}, {31'd0, e.flt});
               chk(c_pa == e.pa, e.tag, "pa", c_pa, e.pa);
               chk(c_sz == e.sz, e.tag, "size", {30'd0, c_sz}, {30'd0, e.sz});
               chk(c_fa == e.fa, e.tag, "fault addr", c_fa, e.fa);
            end
            @(negedge clk);
            chk(res_valid && res_pa == c_pa && res_fault_addr == c_fa, "R10", "result held",
                res_pa, c_pa);
            res_ack = 1'b1;
            @(negedge clk);
            res_ack = 1'b0;
            chk(!res_valid && req_ready, "R10", "release after ack",
                {30'd0, res_valid, req_ready}, 32'd1);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      // Table image
      mem[ROOT_A + 32'h004] = 32'h2340_0002;                      // section
      for (int i = 16'h010; i <= 16'h01F; i++)
         mem[ROOT_A + 32'(i * 4)] = 32'h5604_0002;                // supersection, replicated
      mem[ROOT_A + 32'h080] = L2_TBL | 32'h1;                     // table pointer
      mem[ROOT_A + 32'h084] = 32'h0010_07FD;                      // pointer with junk low bits
      mem[ROOT_A + 32'hC04] = 32'hABCD_0003;                      // bad first-level code
      mem[L2_TBL + 32'h014] = 32'h7777_7002;                      // small page
      mem[L2_TBL + 32'h01C] = 32'h1234_5003;                      // bad second-level code
      for (int i = 16'h30; i <= 16'h3F; i++)
         mem[L2_TBL + 32'(i * 4)] = 32'h8888_0001;                // large page, replicated
      mem[ROOT_B + 32'h004] = 32'h9990_0002;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "req_ready after reset", {31'd0, req_ready}, 32'd1);
      chk(res_valid == 1'b0, "R1", "res_valid after reset", {31'd0, res_valid}, 32'd0);
      chk(mem_rd_valid == 1'b0, "R1", "mem_rd_valid after reset", {31'd0, mem_rd_valid}, 32'd0);

      drive(32'h0012_3456, ROOT_A, "R3 section", 0);
      drive(32'h0012_3456, ROOT_A | 32'h1AB, "R2 root low bits", 0);
      drive(32'h0012_3456, ROOT_B, "R2 other root", 0);
      drive(32'h0135_6789, ROOT_A, "R4 supersection", 0);
      drive(32'h01F0_0004, ROOT_A, "R4 last replica", 0);
      drive(32'h0200_5ABC, ROOT_A, "R6 small page", 0);
      drive(32'h0203_4DEF, ROOT_A, "R7 large page", 0);
      drive(32'h0203_F000, ROOT_A, "R7 last replica", 0);
      drive(32'h0210_5000, ROOT_A, "R5 pointer low bits", 0);
      drive(32'h0200_6000, ROOT_A, "R8 empty second level", 0);
      drive(32'h0200_7123, ROOT_A, "R8 bad second code", 0);
      drive(32'h3000_0010, ROOT_A, "R8 empty first level", 0);
      drive(32'h3010_0000, ROOT_A, "R8 bad first code", 0);
      drive(32'h0200_5ABC, ROOT_A, "R9 busy poke", 1);
      drive(32'h0135_6789, ROOT_A, "R9 after poke", 0);

      while (res_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(rd_q.size() == 0, "R5", "reads outstanding", rd_q.size(), 32'd0);
      summary();
      $finish;
   end

endmodule